// File: doc/BRIEF.md
# Multiplexed LCD Display Memory Controller

This block keeps the picture for a multiplexed segment LCD of 60 segment lines and up to 8 backplanes. The memory holds 60 columns of 8 bits. Column n drives segment line n, and row r is shown while backplane r is active. A stored 1 turns the element on and a stored 0 turns it off. Display bytes arrive on a valid/data port and are unpacked in the cycle they arrive. Each byte is split into bit groups whose size follows the multiplex mode: 1, 2, 4, 6 or 8 rows per column. A column pointer advances after each group, and a bit pointer lets a 1:6 group straddle two bytes. A load strobe places the column pointer anywhere.

A two-state scanner steps through the rows the current mode uses, one row per `scan_tick`.
- In `SCAN_LOAD` it copies the selected RAM row into a display register.
- In `SCAN_HOLD` it keeps that register frozen, so writes never disturb a backplane slot that is being shown.

The transitions are:
- Reset enters `SCAN_LOAD`.
- `SCAN_LOAD` goes to `SCAN_HOLD` after one cycle, or stays in `SCAN_LOAD` on a mode change.
- `SCAN_HOLD` goes to `SCAN_LOAD` on a tick (advance the row) or on a mode change (row 0). Otherwise it stays in `SCAN_HOLD`.

Top module: `lcd_dram_ctrl`

## Requirements
- R1: After reset the RAM is all 0 (all off), `seg_out` is 0, `bp_index` is 0 and static mode is selected.
- R2: A 1 in the RAM drives the matching `seg_out` bit high while its row is displayed, and a 0 drives it low. `seg_out[n]` is column n.
- R3: In static mode (`mode_sel`=0) a byte fills row 0 of 8 consecutive columns. Bit 7 goes to the first column and bit 0 to the last.
- R4: In 1:2 (`mode_sel`=1) and 1:4 (`mode_sel`=2) modes a byte fills 4 or 2 columns. Bits are taken MSB first, and within each column the first bit of its group goes to row 0.
- R5: In 1:6 mode (`mode_sel`=3) the bits fill rows 0..5 MSB first and then move to the next column. The leftover bits of a byte carry into the next column's lower rows, and the next byte continues from there.
- R6: In 1:8 mode (`mode_sel`=4) a byte fills one column, with bit 7 in row 0 and bit 0 in row 7.
- R7: The column pointer wraps from 59 to 0.
- R8: `addr_load` sets the column pointer to `addr_col` and clears the bit pointer; values of 60 and above load 0. When `wr_valid` is high in the same cycle, that byte is written starting at the loaded column.
- R9: A `scan_tick` seen in `SCAN_HOLD` advances the row modulo the active row count (1, 2, 4, 6 or 8). The new row appears on `seg_out` and `bp_index` two clock edges after the tick edge. A tick in the cycle right after that edge falls in `SCAN_LOAD` and is dropped.
- R10: `seg_out` and `bp_index` stay fixed during a slot. A RAM write to the row being shown appears only at the next reload of that row.
- R11: A change of `mode_sel` resets the bit pointer and the row to 0 and reloads row 0 by the second edge. The column pointer is kept.
- R12: `mode_sel` codes 5 to 7 behave as static mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Multiplex mode: 0 static, 1 1:2, 2 1:4, 3 1:6, 4 1:8 |
| addr_load | input | 1 | Load strobe for the column pointer |
| addr_col | input | 6 | Column loaded by `addr_load` |
| wr_valid | input | 1 | `wr_data` holds a display byte this cycle |
| wr_data | input | 8 | Display byte, MSB unpacked first |
| scan_tick | input | 1 | Advance to the next backplane slot |
| seg_out | output | 60 | Segment on/off vector of the displayed row |
| bp_index | output | 3 | Index of the displayed row (active backplane) |

## Verification
Each mode receives a byte written together with an address load, then a second byte that relies on auto-increment alone. The whole RAM is then read back row by row in 1:8 mode, which separates bit-order errors from group-size errors and from pointer-advance errors. The 1:6 cases start near column 58, so a straddling group and a wrap to column 0 happen in the same pattern. An out-of-range load shows whether the pointer clamps. Directed cases cover the following:
- back-to-back ticks (the dropped second tick);
- a write into the row on display (frame stability);
- a mode change in the middle of a column (pointer kept, bit pointer reset);
- the invalid mode codes.

// File: rtl/lcd_dram_pkg.sv
package lcd_dram_pkg;

    typedef enum logic [2:0] {
        MODE_STATIC = 3'd0,
        MODE_MUX2   = 3'd1,
        MODE_MUX4   = 3'd2,
        MODE_MUX6   = 3'd3,
        MODE_MUX8   = 3'd4
    } lcd_mode_e;

    typedef enum logic {
        SCAN_LOAD = 1'b0,
        SCAN_HOLD = 1'b1
    } scan_state_e;

    // Rows per column used by a mode code; unknown codes act as static
    function automatic logic [3:0] active_rows(input logic [2:0] code);
        case (code)
            MODE_MUX2: return 4'd2;
            MODE_MUX4: return 4'd4;
            MODE_MUX6: return 4'd6;
            MODE_MUX8: return 4'd8;
            default:   return 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/lcd_dram_wrptr.sv
module lcd_dram_wrptr #(
    parameter int NUM_COLS = 60,
    parameter int NUM_ROWS = 8,
    parameter int BYTE_W   = 8,
    localparam int COL_W   = $clog2(NUM_COLS),
    localparam int ROW_W   = $clog2(NUM_ROWS),
    localparam int CNT_W   = ROW_W + 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_valid,
    input  logic                            addr_load,
    input  logic [COL_W-1:0]                addr_col,
    input  logic [CNT_W-1:0]                rows_act,
    input  logic                            mode_chg,
    output logic [BYTE_W-1:0][COL_W-1:0]    tgt_col,
    output logic [BYTE_W-1:0][ROW_W-1:0]    tgt_row
);

    logic [COL_W-1:0] col_ptr, start_col, col_walk;
    logic [ROW_W-1:0] bit_ptr, start_bit, bit_walk;

    // Start position: a load or a mode change restarts the column group
    always_comb begin
        start_col = col_ptr;
        if (addr_load) begin
            start_col = (addr_col >= COL_W'(NUM_COLS)) ? '0 : addr_col;
        end
        start_bit = (addr_load || mode_chg) ? '0 : bit_ptr;
    end

    // Walk the byte MSB first, one target cell per bit
    always_comb begin
        col_walk = start_col;
        bit_walk = start_bit;
        for (int k = 0; k < BYTE_W; k++) begin
            tgt_col[k] = col_walk;
            tgt_row[k] = bit_walk;
            if ({1'b0, bit_walk} == rows_act - 1'b1) begin
                bit_walk = '0;
                col_walk = (col_walk == COL_W'(NUM_COLS - 1)) ? '0 : col_walk + 1'b1;
            end else begin
                bit_walk = bit_walk + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_ptr <= '0;
            bit_ptr <= '0;
        end else if (wr_valid) begin
            col_ptr <= col_walk;
            bit_ptr <= bit_walk;
        end else begin
            col_ptr <= start_col;
            bit_ptr <= start_bit;
        end
    end

endmodule

// File: rtl/lcd_dram_array.sv
module lcd_dram_array #(
    parameter int NUM_COLS = 60,
    parameter int NUM_ROWS = 8,
    parameter int BYTE_W   = 8,
    localparam int COL_W   = $clog2(NUM_COLS),
    localparam int ROW_W   = $clog2(NUM_ROWS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [BYTE_W-1:0]               wr_bits,
    input  logic [BYTE_W-1:0][COL_W-1:0]    tgt_col,
    input  logic [BYTE_W-1:0][ROW_W-1:0]    tgt_row,
    input  logic [ROW_W-1:0]                rd_row,
    output logic [NUM_COLS-1:0]             rd_data
);

    logic [NUM_ROWS-1:0][NUM_COLS-1:0] cells;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < BYTE_W; k++) begin
                cells[tgt_row[k]][tgt_col[k]] <= wr_bits[BYTE_W-1-k];
            end
        end
    end

    assign rd_data = cells[rd_row];

endmodule

// File: rtl/lcd_dram_scan.sv
module lcd_dram_scan
    import lcd_dram_pkg::*;
#(
    parameter int NUM_COLS = 60,
    parameter int NUM_ROWS = 8,
    localparam int ROW_W   = $clog2(NUM_ROWS),
    localparam int CNT_W   = ROW_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_tick,
    input  logic                  mode_chg,
    input  logic [CNT_W-1:0]      rows_act,
    input  logic [NUM_COLS-1:0]   rd_data,
    output logic [ROW_W-1:0]      rd_row,
    output logic [NUM_COLS-1:0]   seg_out,
    output logic [ROW_W-1:0]      bp_index
);

    scan_state_e      state_q, state_d;
    logic [ROW_W-1:0] row_q, row_d;

    always_comb begin
        state_d = state_q;
        row_d   = row_q;
        unique case (state_q)
            SCAN_LOAD: begin
                if (mode_chg) begin
                    row_d = '0;
                end else begin
                    state_d = SCAN_HOLD;
                end
            end
            SCAN_HOLD: begin
                if (mode_chg) begin
                    row_d   = '0;
                    state_d = SCAN_LOAD;
                end else if (scan_tick) begin
                    row_d   = ({1'b0, row_q} == rows_act - 1'b1) ? '0 : row_q + 1'b1;
                    state_d = SCAN_LOAD;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SCAN_LOAD;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
        end
    end

    // Display register: only written in the load state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_out  <= '0;
            bp_index <= '0;
        end else if (state_q == SCAN_LOAD) begin
            seg_out  <= rd_data;
            bp_index <= row_q;
        end
    end

    assign rd_row = row_q;

endmodule

// File: rtl/lcd_dram_ctrl.sv
module lcd_dram_ctrl
    import lcd_dram_pkg::*;
#(
    parameter int NUM_COLS = 60,
    parameter int NUM_ROWS = 8,
    parameter int BYTE_W   = 8,
    localparam int COL_W   = $clog2(NUM_COLS),
    localparam int ROW_W   = $clog2(NUM_ROWS),
    localparam int CNT_W   = ROW_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           mode_sel,
    input  logic                 addr_load,
    input  logic [COL_W-1:0]     addr_col,
    input  logic                 wr_valid,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic                 scan_tick,
    output logic [NUM_COLS-1:0]  seg_out,
    output logic [ROW_W-1:0]     bp_index
);

    logic [2:0]                         mode_q;
    logic                               mode_chg;
    logic [CNT_W-1:0]                   rows_act;
    logic [BYTE_W-1:0][COL_W-1:0]       tgt_col;
    logic [BYTE_W-1:0][ROW_W-1:0]       tgt_row;
    logic [ROW_W-1:0]                   rd_row;
    logic [NUM_COLS-1:0]                rd_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_STATIC;
        end else begin
            mode_q <= mode_sel;
        end
    end

    assign mode_chg = (mode_sel != mode_q);
    assign rows_act = CNT_W'(active_rows(mode_sel));

    lcd_dram_wrptr #(
        .NUM_COLS (NUM_COLS),
        .NUM_ROWS (NUM_ROWS),
        .BYTE_W   (BYTE_W)
    ) u_wrptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .addr_load (addr_load),
        .addr_col  (addr_col),
        .rows_act  (rows_act),
        .mode_chg  (mode_chg),
        .tgt_col   (tgt_col),
        .tgt_row   (tgt_row)
    );

    lcd_dram_array #(
        .NUM_COLS (NUM_COLS),
        .NUM_ROWS (NUM_ROWS),
        .BYTE_W   (BYTE_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_valid),
        .wr_bits (wr_data),
        .tgt_col (tgt_col),
        .tgt_row (tgt_row),
        .rd_row  (rd_row),
        .rd_data (rd_data)
    );

    lcd_dram_scan #(
        .NUM_COLS (NUM_COLS),
        .NUM_ROWS (NUM_ROWS)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_tick (scan_tick),
        .mode_chg  (mode_chg),
        .rows_act  (rows_act),
        .rd_data   (rd_data),
        .rd_row    (rd_row),
        .seg_out   (seg_out),
        .bp_index  (bp_index)
    );

endmodule

// File: rtl/lcd_dram_ctrl_chk.sv
module lcd_dram_ctrl_chk
    import lcd_dram_pkg::*;
#(
    parameter int NUM_COLS = 60,
    parameter int NUM_ROWS = 8,
    localparam int COL_W   = $clog2(NUM_COLS),
    localparam int ROW_W   = $clog2(NUM_ROWS),
    localparam int CNT_W   = ROW_W + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           mode_sel,
    input logic                 addr_load,
    input logic [COL_W-1:0]     addr_col,
    input logic                 wr_valid,
    input logic [7:0]           wr_data,
    input logic                 scan_tick,
    input logic [NUM_COLS-1:0]  seg_out,
    input logic [ROW_W-1:0]     bp_index
);

    logic [2:0]       mode_prev;
    logic [2:0]       quiet_cnt;
    logic [2:0]       since_mode;
    logic             mode_evt;
    logic [CNT_W-1:0] rows_now;
    logic [ROW_W-1:0] next_row;

    assign mode_evt = (mode_sel != mode_prev);
    assign rows_now = CNT_W'(active_rows(mode_sel));
    assign next_row = ({1'b0, bp_index} == rows_now - 1'b1) ? '0 : bp_index + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_prev  <= 3'd0;
            quiet_cnt  <= '0;
            since_mode <= '0;
        end else begin
            mode_prev <= mode_sel;
            if (scan_tick || mode_evt) begin
                quiet_cnt <= '0;
            end else if (quiet_cnt != 3'd7) begin
                quiet_cnt <= quiet_cnt + 1'b1;
            end
            if (mode_evt) begin
                since_mode <= '0;
            end else if (since_mode != 3'd7) begin
                since_mode <= since_mode + 1'b1;
            end
        end
    end

    // R10: outputs frozen while no tick or mode change is pending
    a_r10_frame_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_cnt >= 3'd3) |-> ($stable(seg_out) && $stable(bp_index)));

    // R11: a mode change shows row 0 two edges later
    a_r11_mode_row0: assert property (@(posedge clk) disable iff (!rst_n)
        mode_evt |-> ##2 (bp_index == '0));

    // R9: an accepted tick advances the row modulo the active count
    a_r9_tick_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && (quiet_cnt >= 3'd1) && !mode_evt) |-> ##2 (bp_index == $past(next_row, 2)));

    // R12: once settled, the row never reaches the active count (unknown codes give 1)
    a_r12_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (since_mode >= 3'd2) |-> ({1'b0, bp_index} < rows_now));

endmodule

bind lcd_dram_ctrl lcd_dram_ctrl_chk #(
    .NUM_COLS (NUM_COLS),
    .NUM_ROWS (NUM_ROWS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .addr_load (addr_load),
    .addr_col  (addr_col),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .scan_tick (scan_tick),
    .seg_out   (seg_out),
    .bp_index  (bp_index)
);

// File: tb/lcd_dram_ctrl_tb.sv
module lcd_dram_ctrl_tb;

    localparam int COLS = 60;
    localparam int ROWS = 8;

    typedef struct packed {
        logic [2:0] mode;
        logic [5:0] col;
        logic [7:0] data;
        logic [3:0] exp_rows;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{3'd0, 6'd0,  8'hA5, 4'd1},  // R3 static, R2 polarity
        '{3'd1, 6'd20, 8'hC3, 4'd2},  // R4 1:2
        '{3'd2, 6'd30, 8'h96, 4'd4},  // R4 1:4
        '{3'd3, 6'd40, 8'hB7, 4'd6},  // R5 1:6 carry
        '{3'd4, 6'd50, 8'h5E, 4'd8},  // R6 1:8
        '{3'd0, 6'd57, 8'hFF, 4'd1},  // R7 wrap in static
        '{3'd5, 6'd4,  8'h81, 4'd1},  // R12 code 5 acts static
        '{3'd3, 6'd58, 8'h6D, 4'd6},  // R5 and R7 straddle plus wrap
        '{3'd2, 6'd62, 8'h3F, 4'd4},  // R8 out-of-range load
        '{3'd7, 6'd12, 8'h4B, 4'd1}   // R12 code 7 acts static
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [2:0]        mode_sel;
    logic              addr_load;
    logic [5:0]        addr_col;
    logic              wr_valid;
    logic [7:0]        wr_data;
    logic              scan_tick;
    logic [COLS-1:0]   seg_out;
    logic [2:0]        bp_index;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    logic [ROWS-1:0][COLS-1:0] mram;
    int   mcol, mbit, mrow;
    logic [2:0] mmode;

    always #4 clk = ~clk;

    lcd_dram_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .addr_load (addr_load),
        .addr_col  (addr_col),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .scan_tick (scan_tick),
        .seg_out   (seg_out),
        .bp_index  (bp_index)
    );

    function automatic int rows_of(input logic [2:0] m);
        case (m)
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd4:    return 8;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [7:0] d, input bit load, input int col);
        if (load) begin
            mcol = (col >= COLS) ? 0 : col;
            mbit = 0;
        end
        for (int k = 0; k < 8; k++) begin
            mram[mbit][mcol] = d[7-k];
            if (mbit == rows_of(mmode) - 1) begin
                mbit = 0;
                mcol = (mcol == COLS - 1) ? 0 : mcol + 1;
            end else begin
                mbit++;
            end
        end
    endtask

    task automatic write_byte(input logic [7:0] d, input bit load, input int col);
        @(negedge clk);
        wr_valid  = 1'b1;
        wr_data   = d;
        addr_load = load;
        addr_col  = 6'(col);
        @(negedge clk);
        wr_valid  = 1'b0;
        addr_load = 1'b0;
        model_write(d, load, col);
    endtask

    task automatic set_mode(input logic [2:0] m);
        if (m != mmode) begin
            @(negedge clk);
            mode_sel = m;
            mmode    = m;
            mbit     = 0;
            mrow     = 0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        scan_tick = 1'b1;
        @(negedge clk);
        scan_tick = 1'b0;
        mrow = (mrow + 1) % rows_of(mmode);
        @(negedge clk);
    endtask

    // Read all eight rows back through the display port in 1:8 mode
    task automatic dump(input string tag);
        set_mode(3'd4);
        while (mrow != 0) tick();
        for (int r = 0; r < ROWS; r++) begin
            chk($sformatf("%s seg row %0d", tag, r), 64'(seg_out), 64'(mram[r]));
            chk($sformatf("%s bp row %0d", tag, r), 64'(bp_index), 64'(r));
            tick();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired, run hung");
            $display("  CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    initial begin
        logic [COLS-1:0] held;
        logic [7:0]      inv;
        rst_n = 1'b0; mode_sel = 3'd0; addr_load = 1'b0; addr_col = '0;
        wr_valid = 1'b0; wr_data = '0; scan_tick = 1'b0;
        mram = '0; mcol = 0; mbit = 0; mrow = 0; mmode = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 reset seg_out", 64'(seg_out), 64'd0);
        chk("R1 reset bp_index", 64'(bp_index), 64'd0);
        tick();
        chk("R1 static after reset keeps row 0", 64'(bp_index), 64'd0);
        dump("R1 ram cleared");

        // Table walk: load+write (R8), auto-increment byte, row cycle, readback
        for (int i = 0; i < 10; i++) begin
            set_mode(VECS[i].mode);
            write_byte(VECS[i].data, 1'b1, int'(VECS[i].col));
            write_byte(VECS[i].data ^ 8'h5A, 1'b0, 0);
            for (int t = 1; t < int'(VECS[i].exp_rows); t++) tick();
            chk($sformatf("R9 vec %0d last row", i), 64'(bp_index), 64'(VECS[i].exp_rows - 4'd1));
            tick();
            chk($sformatf("R9 vec %0d wrap to row 0", i), 64'(bp_index), 64'd0);
            dump($sformatf("R2 vec %0d", i));
        end

        // R9 back-to-back ticks: the second falls in the load state and is dropped
        set_mode(3'd2);
        @(negedge clk); scan_tick = 1'b1;
        @(negedge clk);
        @(negedge clk); scan_tick = 1'b0;
        mrow = 1;
        @(negedge clk);
        chk("R9 second tick dropped", 64'(bp_index), 64'd1);

        // R10 write into the displayed row leaves the outputs unchanged
        set_mode(3'd4);
        while (mrow != 2) tick();
        held = seg_out;
        for (int k = 0; k < 8; k++) inv[7-k] = ~mram[k][0];
        write_byte(inv, 1'b1, 0);
        chk("R10 seg held after write", 64'(seg_out), 64'(held));
        repeat (4) @(negedge clk);
        chk("R10 seg still held", 64'(seg_out), 64'(held));
        chk("R10 bp held", 64'(bp_index), 64'd2);
        for (int t = 0; t < ROWS; t++) tick();
        chk("R10 new data at next reload", 64'(seg_out), 64'(mram[2]));

        // R11 mode change keeps the column pointer and clears the bit pointer
        while (mrow != 0) tick();
        write_byte(8'h11, 1'b1, 5);
        set_mode(3'd1);
        chk("R11 mode change shows row 0", 64'(bp_index), 64'd0);
        write_byte(8'hE4, 1'b0, 0);
        set_mode(3'd3);
        write_byte(8'hC9, 1'b1, 20);
        set_mode(3'd2);
        write_byte(8'h7E, 1'b0, 0);
        dump("R11 pointers after mode change");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

endmodule